// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which of four candidate clocks drives the main system clock: the frequency-locked loop output, an internal reference oscillator, an external reference oscillator, or the phase-locked loop output. Software writes control fields over a small write-only register bus. The oscillator and both loops are modelled by ready and lock inputs. A change of source only takes effect once the hardware condition for the new source holds. Until then the request stays pending and the reported source does not change.

The source code on `src_sel` steers a glitch-free clock mux outside this block. The same code is the status that software polls before it takes the next step. The rules on legal moves are fixed:
- The phase-locked loop can only be entered from the external reference.
- The external reference waits for the oscillator.
- The frequency-locked loop waits for its lock.

Separate flags confirm the other control bits one cycle after the control bits change: reference choice, fast or slow internal oscillator, and loop choice with its lock.

The block also produces clock enables:
- Four free-running divided enables for the core, bus, external-bus and flash domains.
- A divided tick for the external reference feeding the frequency-locked loop.

A clock monitor, when enabled, latches a loss flag if the oscillator drops while it is in use.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, `src_sel` is 0, `st_ref_int` is 1, `loop_en` is 1, and every other status flag and `switch_done` are 0. The divider fields reset to core 0, bus 0, xbus 0 and flash 1. The reference divider code and the high-range bit reset to 0.
- R2: The register map has three registers:
  - Address 0: bits [1:0] select the source (0 loop, 1 internal, 2 external, 3 no change), bit 2 selects the internal reference for the loop, bit 3 selects the fast internal oscillator, and bit 4 is the low-power bit.
  - Address 1: bits [2:0] are the reference divider code, bit 3 is the high range, bit 4 selects the PLL, and bit 5 enables the monitor.
  - Address 2: four 4-bit divider fields, with core at [3:0], bus at [7:4], xbus at [11:8] and flash at [15:12].
  
  `src_sel` reports 0 for FLL, 1 for internal, 2 for external and 3 for PLL. A move to the internal reference completes on the second clock edge after the write cycle.
- R3: A move to the external reference completes only on an edge where `osc_ready` is high. Until then `src_sel` keeps the old code. `st_osc_init` is `osc_ready` delayed by one cycle.
- R4: `st_pll` follows the PLL-select bit one cycle later. `st_lock` is set only if, on the previous edge, the PLL was selected, `st_pll` was already set, `pll_lock` was high and the loop was enabled.
- R5: With select 0 and `st_pll` set, `src_sel` becomes 3 only from `src_sel` 2 with `st_lock` set. From any other source the request stays pending.
- R6: With select 0 and `st_pll` clear, `src_sel` becomes 0 only on an edge where `fll_lock` is high.
- R7: `st_ref_int` sets one cycle after the reference-select bit is 1. When that bit is 0, the flag clears only on an edge where `osc_ready` is high, and otherwise holds.
- R8: `st_fast_irc` follows the fast-oscillator bit one cycle later.
- R9: `loop_en` is low exactly when the low-power bit is set and the select field is not 0. With select 0, the low-power bit has no effect.
- R10: `switch_done` is high for one cycle, one cycle after `src_sel` takes a new value.
- R11: Each divided enable is high once every (field + 1) cycles. Its counter restarts when it fires.
- R12: `fll_ref_tick` fires once every N cycles. N is 2^code in the low range and 32·2^code in the high range, so code 3 in the high range gives N = 256.
- R13: While the monitor bit is set, `st_clk_loss` latches after any edge where `osc_ready` is low and `src_sel` is 2 or 3. Clearing the monitor bit clears the flag.
- R14: Writes to address 3, and a select value of 3, change no source state. The current `src_sel` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| osc_ready | input | 1 | External oscillator initialized |
| fll_lock | input | 1 | FLL output stable |
| pll_lock | input | 1 | PLL locked |
| src_sel | output | 2 | Source code driving the output mux; also source status |
| loop_en | output | 1 | Loop enable (low in bypass low-power) |
| st_ref_int | output | 1 | Loop reference is the internal oscillator |
| st_fast_irc | output | 1 | Fast internal oscillator selected |
| st_pll | output | 1 | PLL chosen as loop |
| st_lock | output | 1 | PLL lock confirmed |
| st_osc_init | output | 1 | Oscillator initialized flag |
| st_clk_loss | output | 1 | Latched loss of external clock |
| switch_done | output | 1 | One-cycle pulse after a source change |
| div_en | output | 4 | Divided enables: bit 0 core, 1 bus, 2 xbus, 3 flash |
| fll_ref_tick | output | 1 | Divided external reference tick |

## Verification
A wrong source state appears directly on `src_sel` one cycle after the write or input that should have moved it, or failed to move it. A stuck pending request therefore shows up as a code that does not change while its ready or lock input is high. A stale status flag is visible one cycle after its control bit changes. A bad divider counter shows at the latest within one division period, as an enable firing early or late. This holds for up to 4096 cycles on the reference tick. Because every output is compared on every cycle, a single-cycle slip in `switch_done` or in the loss latch is caught on that same cycle.

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
  parameter int DW       = 16,
  parameter int DIVW     = 4,
  parameter int NDIV     = 4,
  parameter int RDW      = 3,
  parameter int HF_SHIFT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            osc_ready,
  input  logic            fll_lock,
  input  logic            pll_lock,
  output logic [1:0]      src_sel,
  output logic            loop_en,
  output logic            st_ref_int,
  output logic            st_fast_irc,
  output logic            st_pll,
  output logic            st_lock,
  output logic            st_osc_init,
  output logic            st_clk_loss,
  output logic            switch_done,
  output logic [NDIV-1:0] div_en,
  output logic            fll_ref_tick
);
  localparam int RCW = HF_SHIFT + (1 << RDW);
  localparam logic [1:0] SRC_FLL = 2'd0, SRC_IRC = 2'd1, SRC_EXT = 2'd2, SRC_PLL = 2'd3;
  localparam logic [NDIV*DIVW-1:0] DIV_RST = {{(DIVW-1){1'b0}}, 1'b1, {((NDIV-1)*DIVW){1'b0}}};

  logic [1:0]           c_sel;
  logic                 c_refint, c_fast, c_lp, c_hf, c_pll, c_mon;
  logic [RDW-1:0]       c_rdiv;
  logic [NDIV*DIVW-1:0] c_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sel <= SRC_FLL; c_refint <= 1'b1; c_fast <= 1'b0; c_lp <= 1'b0;
      c_rdiv <= '0; c_hf <= 1'b0; c_pll <= 1'b0; c_mon <= 1'b0;
      c_div <= DIV_RST;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          c_sel <= wr_data[1:0]; c_refint <= wr_data[2];
          c_fast <= wr_data[3]; c_lp <= wr_data[4];
        end
        2'd1: begin
          c_rdiv <= wr_data[RDW-1:0]; c_hf <= wr_data[RDW];
          c_pll <= wr_data[RDW+1]; c_mon <= wr_data[RDW+2];
        end
        2'd2: c_div <= wr_data[NDIV*DIVW-1:0];
        default: ;
      endcase
    end
  end

  logic       loop_off, ok, upd, upd_q;
  logic [1:0] tgt;

  assign loop_off = c_lp & (c_sel != SRC_FLL);
  assign loop_en  = ~loop_off;

  always_comb begin
    case (c_sel)
      2'd0:    tgt = st_pll ? SRC_PLL : SRC_FLL;
      2'd1:    tgt = SRC_IRC;
      2'd2:    tgt = SRC_EXT;
      default: tgt = src_sel;
    endcase
    case (tgt)
      SRC_FLL: ok = fll_lock;
      SRC_IRC: ok = 1'b1;
      SRC_EXT: ok = osc_ready;
      default: ok = st_lock & (src_sel == SRC_EXT || src_sel == SRC_PLL);
    endcase
  end

  assign upd = ok & (tgt != src_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= SRC_FLL; upd_q <= 1'b0; switch_done <= 1'b0;
      st_ref_int <= 1'b1; st_fast_irc <= 1'b0; st_pll <= 1'b0; st_lock <= 1'b0;
      st_osc_init <= 1'b0; st_clk_loss <= 1'b0;
    end else begin
      if (upd) src_sel <= tgt;
      upd_q       <= upd;
      switch_done <= upd_q;
      st_ref_int  <= c_refint | (st_ref_int & ~osc_ready);
      st_fast_irc <= c_fast;
      st_pll      <= c_pll;
      st_lock     <= c_pll & st_pll & pll_lock & ~loop_off;
      st_osc_init <= osc_ready;
      st_clk_loss <= c_mon & (st_clk_loss |
                     (~osc_ready & (src_sel == SRC_EXT || src_sel == SRC_PLL)));
    end
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic [DIVW-1:0] cnt;
    assign div_en[g] = cnt >= c_div[g*DIVW +: DIVW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (div_en[g]) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  logic [RCW-1:0] r_cnt, r_lim;
  assign r_lim = (c_hf ? ((RCW'(1) << HF_SHIFT) << c_rdiv) : (RCW'(1) << c_rdiv)) - RCW'(1);
  assign fll_ref_tick = r_cnt >= r_lim;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            r_cnt <= '0;
    else if (fll_ref_tick) r_cnt <= '0;
    else                   r_cnt <= r_cnt + 1'b1;
  end

  assert_ext_needs_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(src_sel) && src_sel == SRC_EXT) |-> $past(osc_ready));
  assert_pll_from_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(src_sel) && src_sel == SRC_PLL) |-> ($past(src_sel) == SRC_EXT && $past(st_lock)));
  assert_fll_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(src_sel) && src_sel == SRC_FLL) |-> $past(fll_lock));
  assert_lock_needs_pll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |-> st_pll);
  assert_refst_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_ref_int) |-> $past(osc_ready));
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sel) |=> switch_done);
  assert_loss_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_clk_loss) |-> $past(!osc_ready));
endmodule

// File: tb/clk_src_ctrl_bench.sv
module clk_src_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic osc_ready = 1'b0, fll_lock = 1'b1, pll_lock = 1'b0;
  logic [1:0] src_sel;
  logic loop_en, st_ref_int, st_fast_irc, st_pll, st_lock, st_osc_init, st_clk_loss, switch_done;
  logic [3:0] div_en;
  logic fll_ref_tick;

  always #4 clk = ~clk;

  clk_src_ctrl u_clk_src_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_ready(osc_ready), .fll_lock(fll_lock), .pll_lock(pll_lock),
    .src_sel(src_sel), .loop_en(loop_en), .st_ref_int(st_ref_int), .st_fast_irc(st_fast_irc),
    .st_pll(st_pll), .st_lock(st_lock), .st_osc_init(st_osc_init), .st_clk_loss(st_clk_loss),
    .switch_done(switch_done), .div_en(div_en), .fll_ref_tick(fll_ref_tick));

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0, done = 0;

  int m_sel, m_code, m_src, m_rcnt;
  bit m_refint, m_fast, m_lp, m_hf, m_pll, m_mon;
  bit m_sref, m_sfast, m_spll, m_slock, m_sosc, m_loss, m_upq, m_done;
  int m_div[4], m_cnt[4];

  function automatic int ref_n();
    return (m_hf ? 32 : 1) << m_code;
  endfunction

  task automatic model_reset();
    m_sel = 0; m_refint = 1; m_fast = 0; m_lp = 0; m_code = 0; m_hf = 0; m_pll = 0; m_mon = 0;
    m_div[0] = 0; m_div[1] = 0; m_div[2] = 0; m_div[3] = 1;
    m_src = 0; m_sref = 1; m_sfast = 0; m_spll = 0; m_slock = 0; m_sosc = 0; m_loss = 0;
    m_upq = 0; m_done = 0; m_rcnt = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
  endtask

  task automatic model_step();
    int tgt;
    bit ok, lp_off, n_loss, n_lock, n_sref;
    lp_off = m_lp && m_sel != 0;
    if (m_sel == 0) tgt = m_spll ? 3 : 0;
    else if (m_sel == 3) tgt = m_src;
    else tgt = m_sel;
    case (tgt)
      0: ok = (fll_lock === 1'b1);
      1: ok = 1;
      2: ok = (osc_ready === 1'b1);
      default: ok = m_slock && (m_src == 2 || m_src == 3);
    endcase
    n_loss = m_mon && (m_loss || (osc_ready !== 1'b1 && (m_src == 2 || m_src == 3)));
    n_lock = m_pll && m_spll && (pll_lock === 1'b1) && !lp_off;
    n_sref = m_refint ? 1 : ((osc_ready === 1'b1) ? 0 : m_sref);
    for (int i = 0; i < 4; i++) m_cnt[i] = (m_cnt[i] >= m_div[i]) ? 0 : m_cnt[i] + 1;
    m_rcnt = (m_rcnt >= ref_n() - 1) ? 0 : m_rcnt + 1;
    m_done = m_upq;
    m_upq = ok && tgt != m_src;
    if (m_upq) m_src = tgt;
    m_loss = n_loss; m_slock = n_lock; m_sref = n_sref;
    m_sfast = m_fast; m_spll = m_pll; m_sosc = (osc_ready === 1'b1);
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin m_sel = int'(wr_data[1:0]); m_refint = wr_data[2]; m_fast = wr_data[3]; m_lp = wr_data[4]; end
        2'd1: begin m_code = int'(wr_data[2:0]); m_hf = wr_data[3]; m_pll = wr_data[4]; m_mon = wr_data[5]; end
        2'd2: for (int i = 0; i < 4; i++) m_div[i] = int'((wr_data >> (4*i)) & 16'hF);
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on && rst_n) begin
      chk("R2 R3 R5 R6 src_sel", int'(src_sel), m_src);
      chk("R3 st_osc_init", int'(st_osc_init), int'(m_sosc));
      chk("R4 st_pll", int'(st_pll), int'(m_spll));
      chk("R4 st_lock", int'(st_lock), int'(m_slock));
      chk("R7 st_ref_int", int'(st_ref_int), int'(m_sref));
      chk("R8 st_fast_irc", int'(st_fast_irc), int'(m_sfast));
      chk("R9 loop_en", int'(loop_en), int'(!(m_lp && m_sel != 0)));
      chk("R10 switch_done", int'(switch_done), int'(m_done));
      for (int i = 0; i < 4; i++) chk("R11 div_en", int'(div_en[i]), int'(m_cnt[i] >= m_div[i]));
      chk("R12 fll_ref_tick", int'(fll_ref_tick), int'(m_rcnt >= ref_n() - 1));
      chk("R13 st_clk_loss", int'(st_clk_loss), int'(m_loss));
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 src_sel", int'(src_sel), 0);
    chk("R1 st_ref_int", int'(st_ref_int), 1);
    chk("R1 loop_en", int'(loop_en), 1);
    chk("R1 flags", int'({st_fast_irc, st_pll, st_lock, st_osc_init, st_clk_loss, switch_done}), 0);
    cmp_on = 1;
    idle(6);
    wr(2'd2, 16'h3110); idle(20);
    wr(2'd2, 16'hF70A); idle(40);
    wr(2'd1, 16'h000B); idle(600);
    wr(2'd0, 16'h0002); idle(10);
    osc_ready = 1'b1; idle(6);
    wr(2'd1, 16'h003B); idle(5);
    pll_lock = 1'b1; idle(4);
    wr(2'd0, 16'h0000); idle(6);
    osc_ready = 1'b0; idle(1);
    osc_ready = 1'b1; idle(4);
    wr(2'd1, 16'h001B); idle(3);
    wr(2'd3, 16'hFFFF); idle(2);
    wr(2'd0, 16'h0003); idle(4);
    chk("R14 src held", int'(src_sel), 3);
    wr(2'd0, 16'h0002); idle(4);
    wr(2'd1, 16'h000B); idle(4);
    wr(2'd0, 16'h000D); idle(4);
    wr(2'd0, 16'h001D); idle(4);
    wr(2'd2, 16'h0000); idle(6);
    wr(2'd0, 16'h000D); idle(3);
    wr(2'd1, 16'h001B); idle(4);
    wr(2'd0, 16'h0008); idle(10);
    chk("R5 pending from internal", int'(src_sel), 1);
    wr(2'd0, 16'h0002); idle(4);
    wr(2'd0, 16'h0000); idle(4);
    wr(2'd0, 16'h0010); idle(4);
    fll_lock = 1'b0;
    wr(2'd1, 16'h000B); idle(8);
    chk("R6 pending without lock", int'(src_sel), 3);
    fll_lock = 1'b1; idle(6);
    osc_ready = 1'b0;
    wr(2'd0, 16'h0002); idle(8);
    osc_ready = 1'b1; idle(6);
    wr(2'd1, 16'h0002); idle(40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule